// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five prioritised localities, numbered 0 to 4, owns a shared command interface at any moment, or whether nobody owns it. Software in each locality talks to the block through an 8-bit access register in its own 4 KiB address window. By writing flags to that register it requests ownership, gives ownership up, or takes it by force. A locality with a higher number may take ownership from one with a lower number. When ownership passes to a locality, the block raises a one-cycle locality-changed event.

A hand-over that follows a release or a forced take is not applied at once. The block first sends an abort request to the command engine, naming the locality that gives up the interface and the one that receives it. The new owner is committed only when the engine answers with abort-done. While that abort is outstanding, ownership writes are held off. Granting an interface that nobody owns, and releasing it when no other locality is waiting, both take effect on the same write.

The current owner is visible on `active_loc`, where 8'hFF means no owner. Reads of the access register are combinational. The pending-request indication is computed on each read from the request flags of the other localities.

Top module: `loc_arbiter`

## Requirements
- R1: After reset no locality owns the interface (`active_loc` = 8'hFF), and `loc_chg` and `abort_req` are low. The access register has this layout: bit0 is the inverse of `established`, bit1 request-use, bit2 pending-request, bit3 seize (always reads 0), bit4 been-seized, bit5 active, bit6 reads 0 and bit7 always reads 1. At reset, with `established` = 1, every locality reads 8'h80; with `established` = 0 it reads 8'h81.
- R2: The locality number is `addr[14:12]`, and the access register sits at offset 0 (`addr[11:0]` = 0). A read at any other offset, or in a window numbered 5 to 7, returns 8'hFF. A write there changes nothing.
- R3: A request-use write (bit1) while nobody owns the interface makes the writer the owner at once. In the cycle after the write, `active_loc` shows the writer and `loc_chg` is high for one cycle.
- R4: A request-use write while a different locality owns the interface latches request-use for the writer. Pending-request reads 1 in every locality except the only one holding request-use.
- R5: A write of the active bit (bit5) by a locality that does not own the interface clears that locality's request-use.
- R6: A write of the active bit by the owner releases the interface. If any locality holds request-use, `abort_req` pulses in the next cycle with `abort_from` = owner and `abort_to` = the highest-numbered requester. If no locality holds request-use, the interface becomes unowned at once and `loc_chg` stays low.
- R7: On `abort_done`, the locality in `abort_to` becomes the owner, with its request-use cleared, and `loc_chg` pulses. On a normal hand-over the old owner loses both active and request-use.
- R8: A seize write (bit3) is accepted only when nobody owns the interface, or when the writer's number is higher than the owner's. When accepted, `abort_req` pulses with `abort_to` = writer and `abort_from` = owner, or 8'hFF if there is no owner. The request-use and active bits carried in the same write are ignored.
- R9: When a seize is committed, the old owner gets been-seized (bit4) set and keeps its request-use. The seize flag never reads back. Writing bit4 clears been-seized.
- R10: Every write into locality 4's window is ignored.
- R11: While an abort is outstanding, writes to the access register change nothing except clearing been-seized. A write held off this way is dropped, not queued. `abort_done` has no effect when no abort is outstanding.
- R12: `abort_req` is high for exactly one cycle per accepted release or seize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | 15 | Byte address; bits [14:12] select the locality window |
| wdata | input | 8 | Write data for the access register |
| established | input | 1 | Establishment flag from the executor; bit0 of each read is its inverse |
| rdata | output | 8 | Combinational read data at `addr` |
| abort_req | output | 1 | One-cycle pulse asking the command engine to abort |
| abort_from | output | 8 | Locality that gives up the interface (8'hFF if none) |
| abort_to | output | 8 | Locality that receives the interface after the abort |
| abort_done | input | 1 | Command engine reports that the abort is finished |
| active_loc | output | 8 | Current owner, 8'hFF when unowned |
| loc_chg | output | 1 | One-cycle pulse when ownership passes to a locality |

## Verification
The hardest state to reach is an outstanding abort on which other writes are attempted. The bench holds `abort_done` low after a release. It then issues a seize that would otherwise be accepted, and checks that this seize produces no second abort either then or after the commit. The been-seized path needs a chain of steps: a low locality first gets ownership, a higher one seizes, and the bench completes the handshake. Then the bench reads the old owner's bit4, clears it, and reads it again. The highest-requester choice is exercised with requesters on both sides of the releasing owner.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned NUM_LOC = 5;
  localparam logic [7:0] NO_LOC = 8'hFF;
  localparam int unsigned B_EST    = 0;
  localparam int unsigned B_REQ    = 1;
  localparam int unsigned B_PEND   = 2;
  localparam int unsigned B_SEIZE  = 3;
  localparam int unsigned B_SEIZED = 4;
  localparam int unsigned B_ACT    = 5;
  localparam int unsigned B_VALID  = 7;

  function automatic logic loc_valid(input logic [7:0] l);
    return l < 8'(NUM_LOC);
  endfunction

  // highest-numbered locality with a request flag, or NO_LOC
  function automatic logic [7:0] top_requester(input logic [NUM_LOC-1:0] req);
    logic [7:0] r;
    r = NO_LOC;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req[i]) r = 8'(i);
    end
    return r;
  endfunction

  // any flag set strictly above position idx
  function automatic logic flag_above(input logic [NUM_LOC-1:0] v, input logic [7:0] idx);
    logic f;
    f = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (8'(i) > idx && v[i]) f = 1'b1;
    end
    return f;
  endfunction

  // any flag set other than position idx
  function automatic logic flag_other(input logic [NUM_LOC-1:0] v, input logic [7:0] idx);
    logic f;
    f = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (8'(i) != idx && v[i]) f = 1'b1;
    end
    return f;
  endfunction
endpackage

// File: rtl/loc_addr_dec.sv
module loc_addr_dec
  import loc_arb_pkg::*;
#(
  parameter int unsigned WIN_SHIFT = 12,
  parameter int unsigned LOC_BITS  = 3,
  localparam int unsigned ADDR_W = WIN_SHIFT + LOC_BITS
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        loc_id,
  output logic              acc_hit
);
  always_comb begin
    loc_id  = 8'(addr[ADDR_W-1:WIN_SHIFT]);
    acc_hit = (addr[WIN_SHIFT-1:0] == '0) && loc_valid(loc_id);
  end
endmodule

// File: rtl/loc_abort_ctl.sv
module loc_abort_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_from,
  input  logic [7:0] start_to,
  input  logic       done_in,
  output logic       busy,
  output logic       commit,
  output logic       abort_req,
  output logic [7:0] abort_from,
  output logic [7:0] abort_to
);
  import loc_arb_pkg::*;

  assign commit = busy && done_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      abort_req  <= 1'b0;
      abort_from <= NO_LOC;
      abort_to   <= NO_LOC;
    end else begin
      abort_req <= 1'b0;
      if (commit) begin
        busy <= 1'b0;
      end else if (start && !busy) begin
        busy       <= 1'b1;
        abort_req  <= 1'b1;
        abort_from <= start_from;
        abort_to   <= start_to;
      end
    end
  end
endmodule

// File: rtl/loc_acc_rdmux.sv
module loc_acc_rdmux
  import loc_arb_pkg::*;
(
  input  logic               acc_hit,
  input  logic [7:0]         loc_id,
  input  logic [7:0]         owner,
  input  logic [NUM_LOC-1:0] req,
  input  logic [NUM_LOC-1:0] seized,
  input  logic               established,
  output logic [7:0]         rdata
);
  logic [2:0] li;
  assign li = loc_id[2:0];

  always_comb begin
    rdata = 8'hFF;
    if (acc_hit) begin
      rdata           = 8'h00;
      rdata[B_VALID]  = 1'b1;
      rdata[B_ACT]    = (owner == loc_id);
      rdata[B_SEIZED] = seized[li];
      rdata[B_PEND]   = flag_other(req, loc_id);
      rdata[B_REQ]    = req[li];
      rdata[B_EST]    = !established;
    end
  end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned WIN_SHIFT = 12,
  parameter int unsigned LOC_BITS  = 3,
  parameter logic [7:0]  LOCK_LOC  = 8'd4,
  localparam int unsigned ADDR_W = WIN_SHIFT + LOC_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              established,
  output logic [7:0]        rdata,
  output logic              abort_req,
  output logic [7:0]        abort_from,
  output logic [7:0]        abort_to,
  input  logic              abort_done,
  output logic [7:0]        active_loc,
  output logic              loc_chg
);
  logic [7:0]         loc_id;
  logic               acc_hit;
  logic               wr_ok;
  logic               busy;
  logic               commit;
  logic [NUM_LOC-1:0] req_q, req_n;
  logic [NUM_LOC-1:0] seize_q, seize_n;
  logic [NUM_LOC-1:0] seized_q, seized_n;
  logic [7:0]         act_q, act_n;
  logic               chg_n;
  logic               start;
  logic [7:0]         s_from, s_to;
  logic               do_grant;
  logic [7:0]         grant;
  logic [7:0]         w;
  logic [7:0]         nxt;
  logic [2:0]         li;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata[7:6], wdata[B_PEND], wdata[B_EST]};

  loc_addr_dec #(.WIN_SHIFT(WIN_SHIFT), .LOC_BITS(LOC_BITS)) u_dec (
    .addr    (addr),
    .loc_id  (loc_id),
    .acc_hit (acc_hit)
  );

  assign wr_ok = wr_en && acc_hit && (loc_id != LOCK_LOC);
  assign li    = loc_id[2:0];

  loc_abort_ctl u_abort (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_from (s_from),
    .start_to   (s_to),
    .done_in    (abort_done),
    .busy       (busy),
    .commit     (commit),
    .abort_req  (abort_req),
    .abort_from (abort_from),
    .abort_to   (abort_to)
  );

  always_comb begin
    req_n    = req_q;
    seize_n  = seize_q;
    seized_n = seized_q;
    act_n    = act_q;
    start    = 1'b0;
    s_from   = NO_LOC;
    s_to     = NO_LOC;
    do_grant = 1'b0;
    grant    = NO_LOC;
    nxt      = NO_LOC;
    w        = wdata;
    if (w[B_SEIZE]) begin
      w[B_REQ] = 1'b0;
      w[B_ACT] = 1'b0;
    end
    if (wr_ok) begin
      if (w[B_SEIZED]) seized_n[li] = 1'b0;
      if (!busy) begin
        if (w[B_ACT]) begin
          if (act_q == loc_id) begin
            nxt = top_requester(req_q);
            if (loc_valid(nxt)) begin
              start  = 1'b1;
              s_from = loc_id;
              s_to   = nxt;
            end else begin
              do_grant = 1'b1;
              grant    = NO_LOC;
            end
          end else begin
            req_n[li] = 1'b0;
          end
        end
        if (w[B_SEIZE]) begin
          if ((!loc_valid(act_q) || loc_id > act_q) && !seize_q[li] &&
              !flag_above(seize_q, loc_id)) begin
            for (int i = 0; i < NUM_LOC; i++) begin
              if (8'(i) < loc_id) seize_n[i] = 1'b0;
            end
            seize_n[li] = 1'b1;
            start  = 1'b1;
            s_from = act_q;
            s_to   = loc_id;
          end
        end
        if (w[B_REQ] && act_q != loc_id) begin
          if (loc_valid(act_q)) begin
            req_n[li] = 1'b1;
          end else begin
            do_grant = 1'b1;
            grant    = loc_id;
          end
        end
      end
    end
    if (commit) begin
      do_grant = 1'b1;
      grant    = abort_to;
    end
    if (do_grant && grant != act_q && loc_valid(act_q)) begin
      if (loc_valid(grant) && seize_n[grant[2:0]]) seized_n[act_q[2:0]] = 1'b1;
      else req_n[act_q[2:0]] = 1'b0;
    end
    if (do_grant) begin
      act_n = grant;
      if (loc_valid(grant)) begin
        req_n[grant[2:0]]   = 1'b0;
        seize_n[grant[2:0]] = 1'b0;
      end
    end
    chg_n = do_grant && (grant != act_q) && loc_valid(grant);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= '0;
      seize_q  <= '0;
      seized_q <= '0;
      act_q    <= NO_LOC;
      loc_chg  <= 1'b0;
    end else begin
      req_q    <= req_n;
      seize_q  <= seize_n;
      seized_q <= seized_n;
      act_q    <= act_n;
      loc_chg  <= chg_n;
    end
  end

  assign active_loc = act_q;

  loc_acc_rdmux u_rd (
    .acc_hit     (acc_hit),
    .loc_id      (loc_id),
    .owner       (act_q),
    .req         (req_q),
    .seized      (seized_q),
    .established (established),
    .rdata       (rdata)
  );
endmodule

// File: rtl/loc_arbiter_chk.sv
module loc_arbiter_chk #(
  parameter int unsigned WIN_SHIFT = 12,
  parameter int unsigned LOC_BITS  = 3,
  localparam int unsigned ADDR_W = WIN_SHIFT + LOC_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              abort_req,
  input logic [7:0]        abort_from,
  input logic [7:0]        abort_to,
  input logic              abort_done,
  input logic [7:0]        active_loc,
  input logic              loc_chg,
  input logic              busy,
  input logic              commit
);
  // R12
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);

  // R6
  abort_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> (abort_to < 8'd5) && (abort_to != abort_from));

  // R7
  chg_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_chg |-> (active_loc != $past(active_loc)) && (active_loc < 8'd5));

  // R1
  owner_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_loc < 8'd5) || (active_loc == 8'hFF));

  // R10
  lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[ADDR_W-1:WIN_SHIFT] == 3'd4 && !busy && !abort_done)
      |=> $stable(active_loc) && !abort_req);

  // R11
  hold_during_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> $stable(active_loc));
endmodule

bind loc_arbiter loc_arbiter_chk #(.WIN_SHIFT(WIN_SHIFT), .LOC_BITS(LOC_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .abort_req  (abort_req),
  .abort_from (abort_from),
  .abort_to   (abort_to),
  .abort_done (abort_done),
  .active_loc (active_loc),
  .loc_chg    (loc_chg),
  .busy       (busy),
  .commit     (commit)
);

// File: tb/loc_arbiter_bench.sv
module loc_arbiter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        established = 1'b1;
  logic [7:0]  rdata;
  logic        abort_req;
  logic [7:0]  abort_from, abort_to;
  logic        abort_done = 1'b0;
  logic [7:0]  active_loc;
  logic        loc_chg;
  int          total = 0;
  int          fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  loc_arbiter u_loc_arbiter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .established(established), .rdata(rdata), .abort_req(abort_req),
    .abort_from(abort_from), .abort_to(abort_to), .abort_done(abort_done),
    .active_loc(active_loc), .loc_chg(loc_chg)
  );

  function automatic logic [14:0] win(input int l);
    return 15'(l << 12);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_at(input logic [14:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int l, input logic [7:0] v);
    wr_at(win(l), v);
  endtask

  task automatic rd(input string tag, input logic [14:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic done_pulse;
    abort_done = 1'b1;
    @(negedge clk);
    abort_done = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 owner", active_loc, 8'hFF);
    chk("R1 chg", {7'd0, loc_chg}, 8'd0);
    chk("R1 abort", {7'd0, abort_req}, 8'd0);
    rd("R1 read", win(0), 8'h80);
    established = 1'b0;
    rd("R1 est", win(2), 8'h81);
    established = 1'b1;
  endtask

  task automatic t_decode;
    rd("R2 offset", win(0) | 15'h018, 8'hFF);
    rd("R2 window5", win(5), 8'hFF);
    wr_at(win(0) | 15'h018, 8'h02);
    chk("R2 write ignored", active_loc, 8'hFF);
  endtask

  task automatic t_grant;
    wr(1, 8'h02);
    chk("R3 owner", active_loc, 8'd1);
    chk("R3 chg", {7'd0, loc_chg}, 8'd1);
    rd("R3 read", win(1), 8'hA0);
    @(negedge clk);
    chk("R3 chg pulse", {7'd0, loc_chg}, 8'd0);
  endtask

  task automatic t_latch;
    wr(0, 8'h02);
    chk("R4 owner", active_loc, 8'd1);
    chk("R4 no abort", {7'd0, abort_req}, 8'd0);
    rd("R4 req", win(0), 8'h82);
    rd("R4 pend", win(1), 8'hA4);
    wr(3, 8'h02);
    rd("R4 both", win(3), 8'h86);
  endtask

  task automatic t_release_busy;
    wr(1, 8'h20);
    chk("R6 abort", {7'd0, abort_req}, 8'd1);
    chk("R6 from", abort_from, 8'd1);
    chk("R6 to", abort_to, 8'd3);
    wr(2, 8'h08);
    chk("R12 pulse", {7'd0, abort_req}, 8'd0);
    chk("R11 held", active_loc, 8'd1);
    done_pulse();
    chk("R7 owner", active_loc, 8'd3);
    chk("R7 chg", {7'd0, loc_chg}, 8'd1);
    @(negedge clk);
    chk("R11 dropped", {7'd0, abort_req}, 8'd0);
    rd("R7 old", win(1), 8'h84);
    rd("R7 new", win(3), 8'hA4);
    rd("R11 seizer", win(2), 8'h84);
  endtask

  task automatic t_cancel;
    wr(0, 8'h20);
    rd("R5 cleared", win(0), 8'h80);
    rd("R5 owner view", win(3), 8'hA0);
    done_pulse();
    chk("R11 idle done", active_loc, 8'd3);
    chk("R11 idle chg", {7'd0, loc_chg}, 8'd0);
  endtask

  task automatic t_lock;
    wr(4, 8'h02);
    rd("R10 req", win(4), 8'h80);
    chk("R10 owner", active_loc, 8'd3);
    wr(4, 8'h08);
    chk("R10 seize", {7'd0, abort_req}, 8'd0);
  endtask

  task automatic t_unowned;
    wr(3, 8'h20);
    chk("R6 unowned", active_loc, 8'hFF);
    chk("R6 no chg", {7'd0, loc_chg}, 8'd0);
    chk("R6 no abort", {7'd0, abort_req}, 8'd0);
    rd("R6 read", win(3), 8'h80);
  endtask

  task automatic t_seize;
    wr(1, 8'h02);
    chk("R3 regrant", active_loc, 8'd1);
    wr(0, 8'h02);
    wr(0, 8'h08);
    chk("R8 lower", {7'd0, abort_req}, 8'd0);
    wr(2, 8'h0A);
    chk("R8 abort", {7'd0, abort_req}, 8'd1);
    chk("R8 from", abort_from, 8'd1);
    chk("R8 to", abort_to, 8'd2);
    rd("R9 hidden", win(2), 8'h84);
    done_pulse();
    chk("R8 owner", active_loc, 8'd2);
    chk("R8 chg", {7'd0, loc_chg}, 8'd1);
    rd("R9 seized", win(1), 8'h94);
    rd("R9 new", win(2), 8'hA4);
    wr(1, 8'h10);
    rd("R9 clear", win(1), 8'h84);
  endtask

  task automatic t_highest;
    wr(3, 8'h02);
    rd("R4 owner pend", win(2), 8'hA4);
    wr(2, 8'h20);
    chk("R6 high to", abort_to, 8'd3);
    chk("R6 high from", abort_from, 8'd2);
    done_pulse();
    chk("R7 high owner", active_loc, 8'd3);
    rd("R7 keep req", win(0), 8'h82);
    rd("R7 old clr", win(2), 8'h84);
  endtask

  task automatic t_seize_free;
    wr(0, 8'h20);
    rd("R5 clr0", win(0), 8'h80);
    wr(3, 8'h20);
    chk("R6 free", active_loc, 8'hFF);
    wr(1, 8'h08);
    chk("R8 free abort", {7'd0, abort_req}, 8'd1);
    chk("R8 free from", abort_from, 8'hFF);
    chk("R8 free to", abort_to, 8'd1);
    done_pulse();
    chk("R8 free owner", active_loc, 8'd1);
    chk("R8 free chg", {7'd0, loc_chg}, 8'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_grant();
    t_latch();
    t_release_busy();
    t_cancel();
    t_lock();
    t_unowned();
    t_seize();
    t_highest();
    t_seize_free();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule